// File: doc/BRIEF.md
# Generic Clock Generator Channels

This block provides a bank of generic clock output channels (eight by default). Each channel is set up through its own 32-bit control word on a simple register bus. A control word selects one of four source strobes: two oscillators and two PLLs. It can also turn on an even divider and enable the channel. The sources are single-cycle enable pulses in the block's clock domain. Each channel returns a clock-level output and an enable flag, both in that same domain.

Each channel is a three-state machine. `CH_OFF` holds the output low and the counter clear. `CH_RUN` produces the clock. `CH_HOLD` resynchronises after a reconfiguration.

The transitions are:
- `go_run`: `CH_OFF` to `CH_RUN`, when the enable bit is set.
- `stop`: `CH_RUN` or `CH_HOLD` to `CH_OFF`, when the enable bit is cleared.
- `reconfig`: `CH_RUN` to `CH_HOLD`, when the source or the divider setting changes while the channel is enabled.
- `resync`: `CH_HOLD` to `CH_RUN`, on the first pulse of the newly selected source.

A change that arrives during `CH_HOLD` keeps the channel in `CH_HOLD`.

Top module: `gclk_gen`

## Requirements
- R1: After reset, every control word reads zero, and every clock output and enable flag is low.
- R2: Channel n (0 to NCH-1) is accessed as a word at byte offset 0x60 + 4·n. A write to any other offset, or to an address with bits [1:0] not zero, changes no channel. A read at any such offset returns zero.
- R3: The control word has these fields, and all other bits read as zero:
  - bit 0: source index (1 versus 0).
  - bit 1: PLL versus oscillator.
  - bit 2: channel enable.
  - bit 4: divide enable.
  - bits [15:8]: 8-bit DIV.
  So writing 0xFFFFFFFF reads back 0x0000FF17.
- R4: The source code {bit1, bit0} selects src_tick[0] for 00 (oscillator 0), src_tick[1] for 01 (oscillator 1), src_tick[2] for 10 (PLL0) and src_tick[3] for 11 (PLL1). Pulses on unselected sources have no effect.
- R5: With divide enabled, the output starts low when the channel is enabled and toggles on every (DIV+1)-th selected pulse. The output frequency is therefore source / (2·(DIV+1)), at 50% duty cycle.
- R6: With divide disabled, the output is high for exactly the one cycle that follows each selected pulse, so it passes the source frequency through.
- R7: The enable flag rises one cycle after the cycle of the write that sets the enable bit. After a write that clears it, the output and the enable flag are both low one cycle after the write cycle, and they stay low whatever the sources do.
- R8: A change of the source or divider fields while enabled does three things:
  - It drives the output low one cycle after the write cycle, with the enable flag still high.
  - The first pulse of the new source after that restarts counting from zero.
  - The next edge then comes DIV+1 pulses later.
- R9: Channels are independent: a disabled channel produces no output edges while other channels run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | 4 | Source strobes: oscillator 0, oscillator 1, PLL0, PLL1 |
| gclk_out | output | NCH | Clock-level output per channel |
| gclk_en | output | NCH | Per-channel enable flag (channel not in CH_OFF) |

## Verification
The bench drives all four sources at once, each with a different period, and counts output rising edges over fixed windows. A design that decoded the source code in the wrong bit order, or miscounted the divider by one, would produce a different edge count. Reconfiguration is exercised mid-cycle while the output is high. A design that did not force the output low, that let a pulse on the old source resynchronise, or that kept the stale counter would show an early or missing edge. Register checks cover masked reserved bits, out-of-range and unaligned offsets, and the largest DIV value. A faulty decoder would corrupt a neighbouring channel or read back reserved ones.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

    localparam int DIVW  = 8;
    localparam int SRC_N = 4;
    localparam int SHW   = DIVW + 3;

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic            diven;
        logic            cen;
        logic            pllsel;
        logic            oscsel;
    } gclk_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2
    } gclk_state_e;

    function automatic logic [31:0] cfg_to_word(gclk_cfg_t c);
        logic [31:0] w;
        w                = '0;
        w[0]             = c.oscsel;
        w[1]             = c.pllsel;
        w[2]             = c.cen;
        w[4]             = c.diven;
        w[8 +: DIVW]     = c.div;
        return w;
    endfunction

    function automatic gclk_cfg_t word_to_cfg(logic [31:0] w);
        gclk_cfg_t c;
        c.oscsel = w[0];
        c.pllsel = w[1];
        c.cen    = w[2];
        c.diven  = w[4];
        c.div    = w[8 +: DIVW];
        return c;
    endfunction

endpackage

// File: rtl/gclk_regs.sv
module gclk_regs
    import gclk_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 8,
    parameter int BASE = 'h60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output gclk_cfg_t [NCH-1:0]    cfg_o
);

    localparam int IDXW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BASE_W = BASE / 4;

    logic [31:0] word_i;
    logic [31:0] off;
    logic        hit;
    gclk_cfg_t   cfg_q [NCH];

    always_comb begin
        word_i = 32'(bus_addr) >> 2;
        off    = word_i - 32'(BASE_W);
        hit    = (bus_addr[1:0] == 2'b00) && (word_i >= 32'(BASE_W)) && (off < 32'(NCH));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (bus_wr && hit && (off == 32'(i))) begin
                cfg_q[i] <= word_to_cfg(bus_wdata);
            end
        end
        assign cfg_o[i] = cfg_q[i];
    end

    always_comb begin
        bus_rdata = hit ? cfg_to_word(cfg_q[off[IDXW-1:0]]) : '0;
    end

    // R2: control words only move on a decoded write
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cfg_o));

    p_miss_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(cfg_o));

endmodule

// File: rtl/gclk_chan.sv
module gclk_chan
    import gclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  gclk_cfg_t        cfg,
    input  logic [SRC_N-1:0] src_tick,
    output logic             gclk_out,
    output logic             gclk_en
);

    gclk_state_e     state, nxt;
    logic [DIVW-1:0] cnt;
    logic            out_q;
    logic [SHW-1:0]  shape_now, shape_q;
    logic            chg;
    logic            tick;

    always_comb begin
        tick      = src_tick[{cfg.pllsel, cfg.oscsel}];
        shape_now = {cfg.pllsel, cfg.oscsel, cfg.diven, cfg.div};
        chg       = (shape_now != shape_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shape_q <= '0;
        else        shape_q <= shape_now;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF:  if (cfg.cen) nxt = CH_RUN;
            CH_RUN:  if (!cfg.cen) nxt = CH_OFF;
                     else if (chg) nxt = CH_HOLD;
            CH_HOLD: if (!cfg.cen) nxt = CH_OFF;
                     else if (!chg && tick) nxt = CH_RUN;
            default: nxt = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    // output and divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            out_q <= 1'b0;
        end else begin
            unique case (state)
                CH_RUN: begin
                    if (!cfg.cen || chg) begin
                        cnt   <= '0;
                        out_q <= 1'b0;
                    end else if (!cfg.diven) begin
                        cnt   <= '0;
                        out_q <= tick;
                    end else if (tick) begin
                        if (cnt == cfg.div) begin
                            cnt   <= '0;
                            out_q <= ~out_q;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    cnt   <= '0;
                    out_q <= 1'b0;
                end
            endcase
        end
    end

    assign gclk_out = out_q;
    assign gclk_en  = (state != CH_OFF);

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.cen |=> (!gclk_out && !gclk_en));

    p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_OFF && cfg.cen && chg) |=> (!gclk_out && gclk_en));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && cfg.cen && !chg && !cfg.diven) |=> (gclk_out == $past(tick)));

    p_div_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && cfg.cen && !chg && cfg.diven && !tick) |=> $stable(gclk_out));

endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
    import gclk_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 8,
    parameter int BASE = 'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [SRC_N-1:0] src_tick,
    output logic [NCH-1:0]   gclk_out,
    output logic [NCH-1:0]   gclk_en
);

    gclk_cfg_t [NCH-1:0] cfg;

    gclk_regs #(.NCH(NCH), .AW(AW), .BASE(BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gclk_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg[i]),
            .src_tick (src_tick),
            .gclk_out (gclk_out[i]),
            .gclk_en  (gclk_en[i])
        );
    end

endmodule

// File: tb/gclk_gen_test.sv
module gclk_gen_test;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick;
    logic [NCH-1:0] gout, gen;

    always #5 clk = ~clk;

    gclk_gen uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .gclk_out(gout), .gclk_en(gen)
    );

    typedef struct {
        int    ch;
        int    exp;
        string req;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    rises [NCH];
    logic [NCH-1:0] prev_out = '0;
    bit    mon_on = 1'b0;
    event  win_done;
    int    per [4] = '{2, 3, 5, 7};

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [1:0] sel, logic cen, logic diven, logic [7:0] div);
        return {16'h0, div, 3'b000, diven, 1'b0, cen, sel};
    endfunction

    function automatic int ticks_in(int s, int w);
        int n = 0;
        for (int c = 0; c < w; c++) if (c % per[s] == 0) n++;
        return n;
    endfunction

    function automatic int exp_rises(int t, bit diven, int div);
        int tg;
        if (!diven) return t;
        tg = t / (div + 1);
        return (tg + 1) / 2;
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(int s);
        src_tick    = '0;
        src_tick[s] = 1'b1;
        @(negedge clk);
        src_tick = '0;
    endtask

    // monitor: count rising edges away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on)
                for (int c = 0; c < NCH; c++)
                    if (gout[c] && !prev_out[c]) rises[c]++;
            prev_out = gout;
        end
    end

    // scoreboard compare
    initial begin
        forever begin
            @(win_done);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(rises[it.ch] == it.exp, it.req, $sformatf("ch%0d rising edges", it.ch),
                      rises[it.ch], it.exp);
            end
        end
    end

    // driver: configure one channel, push expectations, run a window
    task automatic run(int ch, logic [1:0] sel, bit diven, int div, int w, string req);
        item_t it;
        int s;
        for (int c = 0; c < NCH; c++) wr(8'(8'h60 + 4 * c), 32'h0);
        wr(8'(8'h60 + 4 * ch), mk(sel, 1'b1, diven, 8'(div)));
        repeat (2) @(negedge clk);
        s = int'(sel);
        it.ch = ch; it.exp = exp_rises(ticks_in(s, w), diven, div); it.req = req;
        exp_q.push_back(it);
        for (int c = 0; c < NCH; c++) begin
            if (c != ch) begin
                it.ch = c; it.exp = 0; it.req = "R9";
                exp_q.push_back(it);
            end
        end
        foreach (rises[c]) rises[c] = 0;
        mon_on = 1'b1;
        for (int c = 0; c < w; c++) begin
            for (int k = 0; k < 4; k++) src_tick[k] = (c % per[k] == 0);
            @(negedge clk);
        end
        src_tick = '0;
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        #3 -> win_done;
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_tick = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(gout == '0, "R1", "outputs after reset", gout, 0);
        check(gen == '0, "R1", "enables after reset", gen, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(8'h60 + 4 * c), d);
            check(d == 32'h0, "R1", $sformatf("ch%0d ctl after reset", c), d, 0);
        end

        // R3 field layout, reserved bits
        wr(8'h6C, 32'hFFFF_FFFF);
        rd(8'h6C, d);
        check(d == 32'h0000_FF17, "R3", "all-ones readback", d, 32'h0000_FF17);
        wr(8'h6C, 32'h0);
        wr(8'h60, 32'h0000_A510);
        rd(8'h60, d);
        check(d == 32'h0000_A510, "R3", "divider fields readback", d, 32'h0000_A510);

        // R2 decode: out of range, below base, unaligned
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, d);
        check(d == 32'h0, "R2", "read beyond last channel", d, 0);
        rd(8'h5C, d);
        check(d == 32'h0, "R2", "read below base", d, 0);
        wr(8'h61, 32'h0000_0004);
        rd(8'h60, d);
        check(d == 32'h0000_A510, "R2", "unaligned write ignored", d, 32'h0000_A510);
        rd(8'h7C, d);
        check(d == 32'h0, "R2", "last channel untouched", d, 0);
        check(gen == '0, "R2", "no channel enabled by stray writes", gen, 0);
        wr(8'h60, 32'h0);

        // R7 enable timing
        wr(8'h64, mk(2'b00, 1'b1, 1'b0, 8'd0));
        check(gen[1] == 1'b0, "R7", "enable flag in write cycle+0", gen[1], 0);
        @(negedge clk);
        check(gen[1] == 1'b1, "R7", "enable flag one cycle later", gen[1], 1);
        wr(8'h64, 32'h0);

        // window measurements: R4 source map, R5 divide, R6 passthrough
        run(0, 2'b00, 1'b0, 0,   60,   "R6");
        run(3, 2'b01, 1'b1, 2,   60,   "R4");
        run(5, 2'b10, 1'b1, 0,   60,   "R4");
        run(7, 2'b11, 1'b0, 0,   60,   "R6");
        run(2, 2'b00, 1'b1, 4,   100,  "R5");
        run(4, 2'b00, 1'b1, 255, 1040, "R5");
        for (int c = 0; c < NCH; c++) wr(8'(8'h60 + 4 * c), 32'h0);

        // R5 phase, then R8 reconfiguration while high
        wr(8'h64, mk(2'b00, 1'b1, 1'b1, 8'd1));
        repeat (2) @(negedge clk);
        pulse(0);
        check(gout[1] == 1'b0, "R5", "low after first of two pulses", gout[1], 0);
        pulse(0);
        check(gout[1] == 1'b1, "R5", "high after second pulse", gout[1], 1);
        wr(8'h64, mk(2'b01, 1'b1, 1'b1, 8'd3));
        @(negedge clk);
        check(gout[1] == 1'b0, "R8", "output forced low after change", gout[1], 0);
        check(gen[1] == 1'b1, "R8", "enable kept during hold", gen[1], 1);
        pulse(0);
        check(gout[1] == 1'b0, "R8", "old source pulse does not resync", gout[1], 0);
        for (int k = 0; k < 4; k++) pulse(1);
        check(gout[1] == 1'b0, "R8", "low after resync plus three pulses", gout[1], 0);
        pulse(1);
        check(gout[1] == 1'b1, "R8", "first edge after resync plus DIV+1", gout[1], 1);

        // R7 disable
        wr(8'h64, mk(2'b01, 1'b0, 1'b1, 8'd3));
        @(negedge clk);
        check(gout[1] == 1'b0, "R7", "output low after disable", gout[1], 0);
        check(gen[1] == 1'b0, "R7", "enable low after disable", gen[1], 0);
        for (int k = 0; k < 10; k++) pulse(1);
        check(gout[1] == 1'b0 && gen[1] == 1'b0, "R7", "stays off with pulses",
              {gout[1], gen[1]}, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule